// File: doc/BRIEF.md
# Task Switch Context Sequencer

This block carries out a hardware switch from one task context to another. A start request is first screened against the incoming task's descriptor. If the descriptor is usable, the block then streams the outgoing task's dynamic registers into that task's 104-byte state segment, one 32-bit word per memory transfer. When a nested switch is requested, it also records the outgoing selector in the incoming segment. Finally it reads the incoming task's dynamic registers and its two read-only words back from the new segment. If the descriptor is rejected, the block reports a fault code instead and touches neither memory nor its register outputs.

The memory side is a single valid/ready word port. The block raises `mem_valid` and holds `mem_we`, `mem_addr` and `mem_wdata` steady until the memory answers with `mem_ready`. Each cycle with both signals high is exactly one transfer. On a read, `mem_rdata` is taken in that same cycle. The memory may stall for any number of cycles. The caller must keep all `cur_*` and `tgt_*` inputs and `nested` stable while `busy` is high. When the switch finishes, a one-cycle `done` pulse carries the descriptor type codes that the surrounding logic should write back, and a debug request when the loaded trap bit is set.

Top module: `tsw_seq`

## Requirements
- R1: The descriptor checks run in a fixed priority order, and the first failure sets `fault`. A selector with bit 2 (table indicator) set gives code 1.
- R2: A descriptor type of 0xB (busy) gives code 2. Any type other than 0x9 or 0xB gives code 3. Type 0x9 passes.
- R3: A descriptor whose present bit is 0 gives code 4.
- R4: A byte limit below 103 gives code 5. A limit of exactly 103 is accepted.
- R5: The save phase writes 16 words to the outgoing base: EIP at +0x20, EFLAGS at +0x24, then EAX, ECX, EDX, EBX, ESP, EBP, ESI, EDI at +0x28 to +0x44, then ES, CS, SS, DS, FS, GS at +0x48 to +0x5C. Each selector is zero-extended from 16 bits, and `cur_gpr` carries EAX in bits 31:0.
- R6: On a fault the block makes no memory transfer and leaves every register output unchanged. It holds `fault` until the next `start`, and a successful start clears it to 0.
- R7: Only when `nested` is 1 does the block write the outgoing selector (zero-extended) to the incoming base +0x00. Nothing is ever written to incoming +0x60 or +0x64.
- R8: At `done`, the outputs hold the 16 dynamic words read from incoming +0x20 to +0x5C in the R5 layout. `new_ldt` holds bits 15:0 of +0x60 and `new_iomap` holds bits 31:16 of +0x64. `dbg_req` is high with `done` exactly when bit 0 of +0x64 is 1.
- R9: The address, the direction and the write data stay stable while `mem_valid` is high and `mem_ready` is low. A switch makes exactly 34 transfers, or 35 when nested.
- R10: `done` is a single-cycle pulse. With it, `new_desc_type` is 0xB, and `old_desc_type` is 0x9, or 0xB when nested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a switch (sampled while idle) |
| nested | input | 1 | Switch expects a return; write link, keep old busy |
| cur_sel | input | 16 | Outgoing task segment selector |
| cur_base | input | 32 | Outgoing segment base address |
| cur_eip | input | 32 | Outgoing instruction pointer |
| cur_eflags | input | 32 | Outgoing flags |
| cur_gpr | input | 256 | Outgoing general registers, EAX in bits 31:0 |
| cur_seg | input | 96 | Outgoing segment selectors, ES in bits 15:0 |
| tgt_sel | input | 16 | Incoming selector |
| tgt_type | input | 4 | Incoming descriptor type |
| tgt_limit | input | 20 | Incoming descriptor byte limit |
| tgt_present | input | 1 | Incoming descriptor present bit |
| tgt_base | input | 32 | Incoming segment base address |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts or answers the request |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| busy | output | 1 | Switch in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 3 | Fault code, 0 when none |
| new_eip | output | 32 | Loaded instruction pointer |
| new_eflags | output | 32 | Loaded flags |
| new_gpr | output | 256 | Loaded general registers |
| new_seg | output | 96 | Loaded segment selectors |
| new_ldt | output | 16 | Loaded local table selector |
| new_iomap | output | 16 | Loaded I/O map base |
| dbg_req | output | 1 | Debug request, with done |
| new_desc_type | output | 4 | Type to write to incoming descriptor, with done |
| old_desc_type | output | 4 | Type to write to outgoing descriptor, with done |

## Verification
The bench builds the block with its default parameters: eight general registers, six segment selectors and a minimum limit of 103. These make the full 16-word dynamic frame reachable, put the two read-only words at +0x60 and +0x64, and place the limit boundary between 102 and 103. The memory model stalls at random, so every word is seen both held across stalls and accepted at once. Nested and plain switches are mixed across three segment bases.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int WORD_W = 32;
  localparam int SEL_W = 16;
  localparam int TI_BIT = 2;
  localparam logic [3:0] TYPE_AVAIL = 4'h9;
  localparam logic [3:0] TYPE_BUSY = 4'hB;
  localparam logic [31:0] DYN_OFF = 32'h20;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_TI     = 3'd1,
    FLT_BUSY   = 3'd2,
    FLT_TYPE   = 3'd3,
    FLT_ABSENT = 3'd4,
    FLT_LIMIT  = 3'd5
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SAVE, S_LINK, S_LOAD, S_FIN
  } state_e;
endpackage

// File: rtl/tsw_desc_check.sv
module tsw_desc_check #(
  parameter int LIM_W = 20,
  parameter int MIN_LIMIT = 103
) (
  input  logic [15:0]      sel,
  input  logic [3:0]       dtype,
  input  logic             present,
  input  logic [LIM_W-1:0] limit,
  output tsw_pkg::fault_e  code
);
  import tsw_pkg::*;
  localparam logic [LIM_W-1:0] LIM_MIN = LIM_W'(MIN_LIMIT);

  always_comb begin
    if (sel[TI_BIT])              code = FLT_TI;
    else if (dtype == TYPE_BUSY)  code = FLT_BUSY;
    else if (dtype != TYPE_AVAIL) code = FLT_TYPE;
    else if (!present)            code = FLT_ABSENT;
    else if (limit < LIM_MIN)     code = FLT_LIMIT;
    else                          code = FLT_NONE;
  end
endmodule

// File: rtl/tsw_save_mux.sv
module tsw_save_mux #(
  parameter int NUM_GPR = 8,
  parameter int NUM_SREG = 6,
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0]        idx,
  input  logic [31:0]             eip,
  input  logic [31:0]             eflags,
  input  logic [NUM_GPR*32-1:0]   gpr,
  input  logic [NUM_SREG*16-1:0]  seg,
  output logic [31:0]             word
);
  localparam int GPR_FIRST = 2;
  localparam int SEG_FIRST = GPR_FIRST + NUM_GPR;

  always_comb begin
    word = '0;
    if (idx == IDX_W'(0)) word = eip;
    if (idx == IDX_W'(1)) word = eflags;
    for (int g = 0; g < NUM_GPR; g++)
      if (idx == IDX_W'(GPR_FIRST + g)) word = gpr[g*32 +: 32];
    for (int s = 0; s < NUM_SREG; s++)
      if (idx == IDX_W'(SEG_FIRST + s)) word = {16'h0, seg[s*16 +: 16]};
  end
endmodule

// File: rtl/tsw_load_bank.sv
module tsw_load_bank #(
  parameter int NUM_GPR = 8,
  parameter int NUM_SREG = 6,
  parameter int IDX_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [IDX_W-1:0]        idx,
  input  logic [31:0]             word,
  output logic [31:0]             eip,
  output logic [31:0]             eflags,
  output logic [NUM_GPR*32-1:0]   gpr,
  output logic [NUM_SREG*16-1:0]  seg,
  output logic [15:0]             ldt,
  output logic [15:0]             iomap,
  output logic                    trap
);
  localparam int GPR_FIRST = 2;
  localparam int SEG_FIRST = GPR_FIRST + NUM_GPR;
  localparam int LDT_IDX = SEG_FIRST + NUM_SREG;
  localparam int CTL_IDX = LDT_IDX + 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eip <= '0; eflags <= '0; gpr <= '0; seg <= '0;
      ldt <= '0; iomap <= '0; trap <= 1'b0;
    end else if (cap_en) begin
      if (idx == IDX_W'(0)) eip <= word;
      if (idx == IDX_W'(1)) eflags <= word;
      for (int g = 0; g < NUM_GPR; g++)
        if (idx == IDX_W'(GPR_FIRST + g)) gpr[g*32 +: 32] <= word;
      for (int s = 0; s < NUM_SREG; s++)
        if (idx == IDX_W'(SEG_FIRST + s)) seg[s*16 +: 16] <= word[15:0];
      if (idx == IDX_W'(LDT_IDX)) ldt <= word[15:0];
      if (idx == IDX_W'(CTL_IDX)) begin
        trap  <= word[0];
        iomap <= word[31:16];
      end
    end
  end
endmodule

// File: rtl/tsw_seq.sv
module tsw_seq #(
  parameter int NUM_GPR = 8,
  parameter int NUM_SREG = 6,
  parameter int LIM_W = 20,
  parameter int MIN_LIMIT = 103
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    nested,
  input  logic [15:0]             cur_sel,
  input  logic [31:0]             cur_base,
  input  logic [31:0]             cur_eip,
  input  logic [31:0]             cur_eflags,
  input  logic [NUM_GPR*32-1:0]   cur_gpr,
  input  logic [NUM_SREG*16-1:0]  cur_seg,
  input  logic [15:0]             tgt_sel,
  input  logic [3:0]              tgt_type,
  input  logic [LIM_W-1:0]        tgt_limit,
  input  logic                    tgt_present,
  input  logic [31:0]             tgt_base,
  output logic                    mem_valid,
  output logic                    mem_we,
  output logic [31:0]             mem_addr,
  output logic [31:0]             mem_wdata,
  input  logic                    mem_ready,
  input  logic [31:0]             mem_rdata,
  output logic                    busy,
  output logic                    done,
  output logic [2:0]              fault,
  output logic [31:0]             new_eip,
  output logic [31:0]             new_eflags,
  output logic [NUM_GPR*32-1:0]   new_gpr,
  output logic [NUM_SREG*16-1:0]  new_seg,
  output logic [15:0]             new_ldt,
  output logic [15:0]             new_iomap,
  output logic                    dbg_req,
  output logic [3:0]              new_desc_type,
  output logic [3:0]              old_desc_type
);
  import tsw_pkg::*;

  localparam int DYN_WORDS = 2 + NUM_GPR + NUM_SREG;
  localparam int LOAD_WORDS = DYN_WORDS + 2;
  localparam int IDX_W = $clog2(LOAD_WORDS + 1);
  localparam logic [IDX_W-1:0] SAVE_LAST = IDX_W'(DYN_WORDS - 1);
  localparam logic [IDX_W-1:0] LOAD_LAST = IDX_W'(LOAD_WORDS - 1);

  state_e           state_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      cur_base_q, tgt_base_q;
  logic [15:0]      cur_sel_q;
  logic             nested_q;
  fault_e           fault_q;
  fault_e           chk_code;
  logic [31:0]      save_word;
  logic [31:0]      idx_off;
  logic             xfer;
  logic             trap;

  tsw_desc_check #(.LIM_W(LIM_W), .MIN_LIMIT(MIN_LIMIT)) u_chk (
    .sel(tgt_sel), .dtype(tgt_type), .present(tgt_present),
    .limit(tgt_limit), .code(chk_code)
  );

  tsw_save_mux #(.NUM_GPR(NUM_GPR), .NUM_SREG(NUM_SREG), .IDX_W(IDX_W)) u_mux (
    .idx(idx_q), .eip(cur_eip), .eflags(cur_eflags), .gpr(cur_gpr),
    .seg(cur_seg), .word(save_word)
  );

  tsw_load_bank #(.NUM_GPR(NUM_GPR), .NUM_SREG(NUM_SREG), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .cap_en(xfer && state_q == S_LOAD),
    .idx(idx_q), .word(mem_rdata),
    .eip(new_eip), .eflags(new_eflags), .gpr(new_gpr), .seg(new_seg),
    .ldt(new_ldt), .iomap(new_iomap), .trap(trap)
  );

  assign idx_off   = DYN_OFF + (32'(idx_q) << 2);
  assign mem_valid = (state_q == S_SAVE) || (state_q == S_LINK) || (state_q == S_LOAD);
  assign xfer      = mem_valid && mem_ready;

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      S_SAVE: begin
        mem_we = 1'b1; mem_addr = cur_base_q + idx_off; mem_wdata = save_word;
      end
      S_LINK: begin
        mem_we = 1'b1; mem_addr = tgt_base_q; mem_wdata = {16'h0, cur_sel_q};
      end
      S_LOAD: mem_addr = tgt_base_q + idx_off;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q <= '0;
      cur_base_q <= '0;
      tgt_base_q <= '0;
      cur_sel_q <= '0;
      nested_q <= 1'b0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          fault_q <= chk_code;
          if (chk_code == FLT_NONE) begin
            state_q <= S_SAVE;
            idx_q <= '0;
            cur_base_q <= cur_base;
            tgt_base_q <= tgt_base;
            cur_sel_q <= cur_sel;
            nested_q <= nested;
          end
        end
        S_SAVE: if (xfer) begin
          if (idx_q == SAVE_LAST) begin
            idx_q <= '0;
            state_q <= nested_q ? S_LINK : S_LOAD;
          end else idx_q <= idx_q + 1'b1;
        end
        S_LINK: if (xfer) state_q <= S_LOAD;
        S_LOAD: if (xfer) begin
          if (idx_q == LOAD_LAST) state_q <= S_FIN;
          else idx_q <= idx_q + 1'b1;
        end
        S_FIN: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy          = state_q != S_IDLE;
  assign done          = state_q == S_FIN;
  assign fault         = fault_q;
  assign dbg_req       = done && trap;
  assign new_desc_type = done ? TYPE_BUSY : 4'h0;
  assign old_desc_type = done ? (nested_q ? TYPE_BUSY : TYPE_AVAIL) : 4'h0;
endmodule

// File: rtl/tsw_seq_sva.sv
module tsw_seq_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        dbg_req,
  input logic        mem_valid,
  input logic        mem_we,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [2:0]  fault,
  input logic [3:0]  new_desc_type,
  input logic [3:0]  old_desc_type,
  input logic [31:0] tgt_base_q,
  input logic        nested_q
);
  p_quiet_on_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault != 3'd0) |-> !mem_valid);

  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  p_req_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_types_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_desc_type == 4'hB && old_desc_type == (nested_q ? 4'hB : 4'h9)));

  p_static_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_addr != tgt_base_q + 32'h60 && mem_addr != tgt_base_q + 32'h64));

  p_link_nested_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && mem_addr == tgt_base_q) |-> nested_q);

  p_trap_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> done);
endmodule

bind tsw_seq tsw_seq_sva u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .dbg_req(dbg_req),
  .mem_valid(mem_valid), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .fault(fault), .new_desc_type(new_desc_type),
  .old_desc_type(old_desc_type), .tgt_base_q(tgt_base_q), .nested_q(nested_q)
);

// File: tb/tsw_seq_test.sv
module tsw_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         start = 0, nested = 0;
  logic [15:0]  cur_sel = 0, tgt_sel = 0;
  logic [31:0]  cur_base = 0, tgt_base = 0, cur_eip = 0, cur_eflags = 0;
  logic [255:0] cur_gpr = 0;
  logic [95:0]  cur_seg = 0;
  logic [3:0]   tgt_type = 4'h9;
  logic [19:0]  tgt_limit = 20'd103;
  logic         tgt_present = 1;
  logic         mem_valid, mem_we, mem_ready = 0;
  logic [31:0]  mem_addr, mem_wdata, mem_rdata;
  logic         busy, done, dbg_req;
  logic [2:0]   fault;
  logic [31:0]  new_eip, new_eflags;
  logic [255:0] new_gpr;
  logic [95:0]  new_seg;
  logic [15:0]  new_ldt, new_iomap;
  logic [3:0]   new_desc_type, old_desc_type;

  tsw_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .nested(nested),
    .cur_sel(cur_sel), .cur_base(cur_base), .cur_eip(cur_eip),
    .cur_eflags(cur_eflags), .cur_gpr(cur_gpr), .cur_seg(cur_seg),
    .tgt_sel(tgt_sel), .tgt_type(tgt_type), .tgt_limit(tgt_limit),
    .tgt_present(tgt_present), .tgt_base(tgt_base),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fault(fault), .new_eip(new_eip),
    .new_eflags(new_eflags), .new_gpr(new_gpr), .new_seg(new_seg),
    .new_ldt(new_ldt), .new_iomap(new_iomap), .dbg_req(dbg_req),
    .new_desc_type(new_desc_type), .old_desc_type(old_desc_type)
  );

  logic [31:0] mem [0:255];
  int n_xfer = 0, n_ro_wr = 0, n_link_wr = 0, n_unstable = 0;
  logic        pend = 0;
  logic [31:0] pend_addr, pend_data;
  logic        pend_we;
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_valid && pend && (mem_addr != pend_addr || mem_we != pend_we || mem_wdata != pend_data))
      n_unstable++;
    pend = mem_valid && !mem_ready;
    pend_addr = mem_addr; pend_we = mem_we; pend_data = mem_wdata;
    if (mem_valid && mem_ready) begin
      n_xfer++;
      if (mem_we) begin
        mem[mem_addr[9:2]] = mem_wdata;
        if (mem_addr == tgt_base + 32'h60 || mem_addr == tgt_base + 32'h64) n_ro_wr++;
        if (mem_addr == tgt_base) n_link_wr++;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    mem_ready <= ($urandom % 4) != 0;
  end

  int total = 0, bad = 0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_fault(logic [15:0] s, logic [3:0] t, logic p, logic [19:0] l);
    if (s[2]) return 3'd1;
    if (t == 4'hB) return 3'd2;
    if (t != 4'h9) return 3'd3;
    if (!p) return 3'd4;
    if (l < 20'd103) return 3'd5;
    return 3'd0;
  endfunction

  function automatic logic [31:0] exp_save(int k);
    if (k == 0) return cur_eip;
    if (k == 1) return cur_eflags;
    if (k < 10) return cur_gpr[(k-2)*32 +: 32];
    return {16'h0, cur_seg[(k-10)*16 +: 16]};
  endfunction

  task automatic randomize_ctx(input int cb, input int tb);
    cur_base = 32'(cb) * 32'h100;
    tgt_base = 32'(tb) * 32'h100;
    cur_sel = {$urandom} & 16'hFFF8;
    tgt_sel = {$urandom} & 16'hFFF8;
    cur_eip = $urandom; cur_eflags = $urandom;
    for (int g = 0; g < 8; g++) cur_gpr[g*32 +: 32] = $urandom;
    for (int s = 0; s < 6; s++) cur_seg[s*16 +: 16] = 16'($urandom);
    for (int w = 0; w < 26; w++) mem[tgt_base[9:2] + 8'(w)] = $urandom;
    mem[cur_base[9:2]] = 32'h0;
  endtask

  task automatic pulse_start;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic run_ok(input logic nst, input logic [19:0] lim);
    int x0, l0, wait_n;
    logic [31:0] tw;
    nested = nst; tgt_type = 4'h9; tgt_present = 1; tgt_limit = lim;
    x0 = n_xfer; l0 = n_link_wr;
    pulse_start();
    check(fault == 3'd0, "R6 fault cleared by good start", 32'(fault), 0);
    wait_n = 0;
    while (!done && wait_n < 2000) begin @(negedge clk); wait_n++; end
    check(done, "R10 done reached", 32'(done), 1);
    tw = 32'(tgt_base[9:2]);
    check(new_desc_type == 4'hB, "R10 new type", 32'(new_desc_type), 32'hB);
    check(old_desc_type == (nst ? 4'hB : 4'h9), "R10 old type", 32'(old_desc_type), nst ? 32'hB : 32'h9);
    check(dbg_req == mem[tw + 25][0], "R8 debug request", 32'(dbg_req), 32'(mem[tw + 25][0]));
    check(new_eip == mem[tw + 8] && new_eflags == mem[tw + 9], "R8 eip/eflags", new_eip, mem[tw + 8]);
    for (int g = 0; g < 8; g++)
      check(new_gpr[g*32 +: 32] == mem[tw + 10 + 32'(g)], "R8 gpr", new_gpr[g*32 +: 32], mem[tw + 10 + 32'(g)]);
    for (int s = 0; s < 6; s++)
      check(new_seg[s*16 +: 16] == mem[tw + 18 + 32'(s)][15:0], "R8 seg", 32'(new_seg[s*16 +: 16]), 32'(mem[tw + 18 + 32'(s)][15:0]));
    check(new_ldt == mem[tw + 24][15:0], "R8 ldt", 32'(new_ldt), 32'(mem[tw + 24][15:0]));
    check(new_iomap == mem[tw + 25][31:16], "R8 iomap", 32'(new_iomap), 32'(mem[tw + 25][31:16]));
    for (int k = 0; k < 16; k++)
      check(mem[cur_base[9:2] + 8 + 8'(k)] == exp_save(k), "R5 saved word", mem[cur_base[9:2] + 8 + 8'(k)], exp_save(k));
    check(n_xfer - x0 == (nst ? 35 : 34), "R9 transfer count", 32'(n_xfer - x0), nst ? 35 : 34);
    check(n_link_wr - l0 == (nst ? 1 : 0), "R7 link write count", 32'(n_link_wr - l0), nst ? 1 : 0);
    if (nst) check(mem[tw] == {16'h0, cur_sel}, "R7 link value", mem[tw], {16'h0, cur_sel});
    @(negedge clk);
    check(!done, "R10 done single cycle", 32'(done), 0);
  endtask

  task automatic run_bad(input logic [15:0] s, input logic [3:0] t, input logic p, input logic [19:0] l, input string tag);
    int x0;
    logic [31:0] e0;
    logic [2:0] ef;
    tgt_sel = s; tgt_type = t; tgt_present = p; tgt_limit = l;
    ef = exp_fault(s, t, p, l);
    x0 = n_xfer; e0 = new_eip;
    pulse_start();
    check(fault == ef, tag, 32'(fault), 32'(ef));
    repeat (4) @(negedge clk);
    check(fault == ef && !busy, "R6 fault held", 32'(fault), 32'(ef));
    check(n_xfer == x0 && new_eip == e0, "R6 no traffic or output change", 32'(n_xfer - x0), 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cb, tb;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && fault == 0 && !mem_valid && new_eip == 0, "R6 reset state", 32'(fault), 0);

    randomize_ctx(0, 1);
    run_ok(0, 20'd103);
    check(n_ro_wr == 0, "R7 static fields untouched", 32'(n_ro_wr), 0);
    run_bad(16'h0014, 4'hB, 1, 20'd103, "R1 table bit beats busy");
    run_bad(16'h0010, 4'hB, 1, 20'd200, "R2 busy type");
    run_bad(16'h0010, 4'h1, 0, 20'd200, "R2 other type");
    run_bad(16'h0010, 4'h9, 0, 20'd50, "R3 absent");
    run_bad(16'h0010, 4'h9, 1, 20'd102, "R4 limit 102");
    tgt_sel = 16'h0018;
    mem[tgt_base[9:2] + 25] = mem[tgt_base[9:2] + 25] | 32'h1;
    run_ok(1, 20'd103);

    for (int it = 0; it < 24; it++) begin
      cb = $urandom % 3;
      tb = (cb + 1 + ($urandom % 2)) % 3;
      randomize_ctx(cb, tb);
      run_ok(1'($urandom), 20'd103 + 20'($urandom % 1000));
      if (it % 6 == 0)
        run_bad(16'($urandom), 4'($urandom), 1'($urandom), 20'($urandom % 130), "R1 R2 R3 R4 random descriptor");
    end
    check(n_ro_wr == 0, "R7 static fields never written", 32'(n_ro_wr), 0);
    check(n_unstable == 0, "R9 request stable while stalled", 32'(n_unstable), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule